// File: doc/BRIEF.md
# Line receive interface with violation counter

This block sits between a serial line interface device and a downstream framer. It takes the received line data in one of two forms. In dual-rail form the two rails carry alternate-mark-inversion pulses, one rail per pulse polarity. In binary form one rail carries NRZ data and the other carries a line-code-violation flag from the line interface. The block turns either form into a single recovered NRZ bit stream and counts bipolar violations in a saturating counter.

Each rail has its own polarity invert control, applied before decoding. An edge select control picks whether the rails are sampled on the rising clock edge or on the falling edge before it. In binary mode the violation flag polarity follows the negative-rail invert control. In dual-rail mode the block finds violations on its own by tracking the polarity of the last mark.

Software-side reads work through a latch strobe. The strobe copies the live count into an upper-half and a lower-half byte register and clears the live count in the same cycle. A violation that arrives in that cycle is kept for the next interval, so no count is lost.

Top module: `line_rx_viol`

## Requirements
- R1: With cfg_binary=0, nrz_out is 1 when either rail (after inversion) is high at the sampling instant and 0 otherwise. It shows the value sampled at a given rising edge one rising edge later, so two edges after the input is set up.
- R2: With cfg_binary=1, nrz_out follows rail_p (after inversion) with the R1 latency, and rail_n has no effect on nrz_out.
- R3: cfg_pos_inv=1 inverts rail_p and cfg_neg_inv=1 inverts rail_n before any decoding, in both modes.
- R4: With cfg_binary=1 and cfg_neg_inv=0, the live count rises by one for every sampled cycle in which rail_n is 1, and by at most one per cycle.
- R5: With cfg_binary=1 and cfg_neg_inv=1, the live count rises by one for every sampled cycle in which rail_n is 0.
- R6: With cfg_binary=0, a mark on one rail whose polarity equals that of the previous mark is one violation, and spaces between the marks do not break the chain. The first mark after reset is never a violation. A cycle with both rails high counts as a mark and as one violation, and it leaves the stored polarity unchanged. A cycle with no mark never gives a violation.
- R7: cfg_fall_edge=0 samples the rails on the rising edge. cfg_fall_edge=1 uses the values captured on the falling edge half a cycle before that rising edge.
- R8: The live count saturates at all ones and does not wrap.
- R9: A cycle with latch_stb=1 copies the live count into the output registers, with count_hi holding the upper half and count_lo the lower half of the count. In the same cycle the live count restarts from the violation of that cycle (1 if there is one, else 0).
- R10: After reset, nrz_out, count_hi and count_lo are 0 and no mark polarity is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_binary | input | 1 | 1: binary NRZ plus violation flag, 0: dual-rail AMI |
| cfg_pos_inv | input | 1 | Invert rail_p before decoding |
| cfg_neg_inv | input | 1 | Invert rail_n before decoding |
| cfg_fall_edge | input | 1 | 1: use the falling-edge sample, 0: the rising-edge sample |
| rail_p | input | 1 | Positive pulse rail, or NRZ data in binary mode |
| rail_n | input | 1 | Negative pulse rail, or violation flag in binary mode |
| latch_stb | input | 1 | Copy the count to the output bytes and clear it |
| nrz_out | output | 1 | Recovered NRZ bit stream |
| count_hi | output | CNT_W/2 | Upper half of the latched count |
| count_lo | output | CNT_W/2 | Lower half of the latched count |

## Verification
The bench builds the block with the default CNT_W of 16. This puts saturation within reach, after 65,535 violation cycles of binary flag input, and it lets a count of 300 show a nonzero upper byte. At that width, the carry from count_lo into count_hi and the all-ones hold are both checked on real byte halves. A continuous violation stream across a latch strobe checks the no-loss handover. A set-up-then-change input pattern inside each clock period separates the falling-edge sample from the rising-edge one.

// File: rtl/lrx_pkg.sv
package lrx_pkg;
  typedef enum logic {MARK_POS = 1'b0, MARK_NEG = 1'b1} mark_pol_e;
  localparam int RAIL_P    = 0;
  localparam int RAIL_N    = 1;
  localparam int NUM_RAILS = 2;
endpackage

// File: rtl/lrx_sampler.sv
module lrx_sampler #(
  parameter int RAILS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall_sel,
  input  logic [RAILS-1:0] inv,
  input  logic [RAILS-1:0] raw,
  output logic [RAILS-1:0] smp
);
  for (genvar g = 0; g < RAILS; g++) begin : g_rail
    logic fall_q;
    logic smp_q;
    // half-cycle capture register, used when falling-edge sampling is chosen
    always_ff @(negedge clk) begin
      if (rst) fall_q <= 1'b0;
      else     fall_q <= raw[g];
    end
    always_ff @(posedge clk) begin
      if (rst) smp_q <= 1'b0;
      else     smp_q <= (fall_sel ? fall_q : raw[g]) ^ inv[g];
    end
    assign smp[g] = smp_q;
  end
endmodule

// File: rtl/lrx_decoder.sv
module lrx_decoder
  import lrx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic binary,
  input  logic smp_p,
  input  logic smp_n,
  output logic nrz_q,
  output logic viol_q
);
  mark_pol_e last_pol;
  logic      have_mark;

  always_ff @(posedge clk) begin
    if (rst) begin
      nrz_q     <= 1'b0;
      viol_q    <= 1'b0;
      last_pol  <= MARK_POS;
      have_mark <= 1'b0;
    end else if (binary) begin
      nrz_q  <= smp_p;
      viol_q <= smp_n;
    end else begin
      nrz_q <= smp_p | smp_n;
      unique case ({smp_p, smp_n})
        2'b11: viol_q <= 1'b1;
        2'b10: begin
          viol_q    <= have_mark && (last_pol == MARK_POS);
          last_pol  <= MARK_POS;
          have_mark <= 1'b1;
        end
        2'b01: begin
          viol_q    <= have_mark && (last_pol == MARK_NEG);
          last_pol  <= MARK_NEG;
          have_mark <= 1'b1;
        end
        default: viol_q <= 1'b0;
      endcase
    end
  end

  // R6
  quiet_no_viol_chk: assert property (@(posedge clk) disable iff (rst)
    (!binary && !smp_p && !smp_n) |=> !viol_q);
endmodule

// File: rtl/lrx_viol_counter.sv
module lrx_viol_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             viol,
  input  logic             latch_stb,
  output logic [CNT_W-1:0] snap_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else if (latch_stb) begin
      snap_q <= cnt_q;
      cnt_q  <= {{(CNT_W-1){1'b0}}, viol};
    end else if (viol && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R8
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !latch_stb) |=> (cnt_q == CNT_MAX));
  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !latch_stb |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R9
  latch_clear_chk: assert property (@(posedge clk) disable iff (rst)
    latch_stb |=> (cnt_q <= CNT_W'(1)));
  // R9
  snap_copy_chk: assert property (@(posedge clk) disable iff (rst)
    latch_stb |=> (snap_q == $past(cnt_q)));
endmodule

// File: rtl/line_rx_viol.sv
module line_rx_viol
  import lrx_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_binary,
  input  logic              cfg_pos_inv,
  input  logic              cfg_neg_inv,
  input  logic              cfg_fall_edge,
  input  logic              rail_p,
  input  logic              rail_n,
  input  logic              latch_stb,
  output logic              nrz_out,
  output logic [HALF_W-1:0] count_hi,
  output logic [HALF_W-1:0] count_lo
);
  logic [NUM_RAILS-1:0] raw, inv, smp;
  logic                 viol;
  logic [CNT_W-1:0]     snap;

  assign raw[RAIL_P] = rail_p;
  assign raw[RAIL_N] = rail_n;
  assign inv[RAIL_P] = cfg_pos_inv;
  assign inv[RAIL_N] = cfg_neg_inv;

  lrx_sampler #(.RAILS(NUM_RAILS)) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .fall_sel (cfg_fall_edge),
    .inv      (inv),
    .raw      (raw),
    .smp      (smp)
  );

  lrx_decoder u_decoder (
    .clk    (clk),
    .rst    (rst),
    .binary (cfg_binary),
    .smp_p  (smp[RAIL_P]),
    .smp_n  (smp[RAIL_N]),
    .nrz_q  (nrz_out),
    .viol_q (viol)
  );

  lrx_viol_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .viol      (viol),
    .latch_stb (latch_stb),
    .snap_q    (snap)
  );

  assign count_hi = snap[CNT_W-1:HALF_W];
  assign count_lo = snap[HALF_W-1:0];
endmodule

// File: tb/line_rx_viol_bench.sv
module line_rx_viol_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_binary = 1'b0, cfg_pos_inv = 1'b0, cfg_neg_inv = 1'b0, cfg_fall_edge = 1'b0;
  logic       rail_p = 1'b0, rail_n = 1'b0, latch_stb = 1'b0;
  logic       nrz_out;
  logic [7:0] count_hi, count_lo;

  int    checks = 0, fails = 0, hv = 0;
  logic  e1 = 1'b0, e2 = 1'b0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  line_rx_viol u_line_rx_viol (
    .clk(clk), .rst(rst), .cfg_binary(cfg_binary), .cfg_pos_inv(cfg_pos_inv),
    .cfg_neg_inv(cfg_neg_inv), .cfg_fall_edge(cfg_fall_edge), .rail_p(rail_p),
    .rail_n(rail_n), .latch_stb(latch_stb), .nrz_out(nrz_out),
    .count_hi(count_hi), .count_lo(count_lo)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // compares nrz_out with the expectation from two steps back, then shifts
  task automatic hist(input logic exp);
    if (hv >= 2) check(cur_req, nrz_out, e2);
    e2 = e1;
    e1 = exp;
    hv++;
  endtask

  task automatic step(input logic p, input logic n, input logic l, input logic exp);
    @(posedge clk);
    #2;
    rail_p = p; rail_n = n; latch_stb = l;
    #4;
    hist(exp);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(cfg_pos_inv, cfg_neg_inv, 1'b0, 1'b0);
  endtask

  task automatic read_count(output int val);
    idle(4);
    step(cfg_pos_inv, cfg_neg_inv, 1'b1, 1'b0);
    step(cfg_pos_inv, cfg_neg_inv, 1'b0, 1'b0);
    val = {count_hi, count_lo};
  endtask

  task automatic do_reset(input logic bin, input logic pinv, input logic ninv, input logic fall);
    @(posedge clk);
    #2;
    rst = 1'b1;
    cfg_binary = bin; cfg_pos_inv = pinv; cfg_neg_inv = ninv; cfg_fall_edge = fall;
    rail_p = pinv; rail_n = ninv; latch_stb = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    hv = 0;
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0, 1'b0, 1'b0);
    #4;
    check("R10 nrz", nrz_out, 0);
    check("R10 hi", count_hi, 0);
    check("R10 lo", count_lo, 0);
  endtask

  task automatic t_dual();
    int v;
    do_reset(1'b0, 1'b0, 1'b0, 1'b0);
    cur_req = "R1";
    // first mark after reset never a violation (R6)
    step(1, 0, 0, 1); step(0, 0, 0, 0); step(0, 1, 0, 1); step(0, 0, 0, 0);
    step(1, 0, 0, 1); step(1, 0, 0, 1);                    // +1
    step(0, 0, 0, 0); step(0, 0, 0, 0); step(1, 0, 0, 1);  // +1 across spaces
    step(0, 1, 0, 1); step(0, 1, 0, 1);                    // +1
    step(1, 1, 0, 1);                                      // +1 both rails
    step(0, 1, 0, 1);                                      // +1 memory still negative
    read_count(v);
    check("R6 dual violations", v, 5);
  endtask

  task automatic t_binary();
    int v;
    logic [7:0] pd = 8'b0100_1101, nd = 8'b1000_1011;
    do_reset(1'b1, 1'b0, 1'b0, 1'b0);
    cur_req = "R2";
    for (int i = 0; i < 8; i++) step(pd[i], nd[i], 0, pd[i]);
    read_count(v);
    check("R4 flag count", v, 4);
  endtask

  task automatic t_neg_inv();
    int v;
    logic [4:0] nd = 5'b10010;
    do_reset(1'b1, 1'b0, 1'b1, 1'b0);
    cur_req = "R5";
    for (int i = 0; i < 5; i++) step(0, nd[i], 0, 0);
    read_count(v);
    check("R5 inverted flag count", v, 3);
  endtask

  task automatic t_pos_inv();
    int v;
    logic [5:0] pd = 6'b011010;
    do_reset(1'b1, 1'b1, 1'b0, 1'b0);
    cur_req = "R3";
    for (int i = 0; i < 6; i++) step(pd[i], 0, 0, ~pd[i]);
    idle(3);
    do_reset(1'b0, 1'b0, 1'b1, 1'b0);
    step(0, 1, 0, 0); step(0, 0, 0, 1); step(0, 1, 0, 0); step(0, 0, 0, 1);
    read_count(v);
    check("R3 inverted n rail marks", v, 1);
  endtask

  // value a before the falling edge, value b after it
  task automatic split_step(input logic a, input logic b, input logic exp);
    @(posedge clk);
    #2;
    rail_p = a;
    #3;
    rail_p = b;
    #1;
    hist(exp);
  endtask

  task automatic t_edge();
    logic [3:0] ad = 4'b0110, bd = 4'b1010;
    cur_req = "R7";
    do_reset(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) split_step(ad[i], bd[i], bd[i]);
    idle(3);
    do_reset(1'b1, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) split_step(ad[i], bd[i], ad[i]);
    idle(3);
  endtask

  task automatic t_latch();
    int s1 = 0, s2;
    do_reset(1'b1, 1'b0, 1'b0, 1'b0);
    cur_req = "R9";
    for (int i = 0; i < 20; i++) begin
      step(0, 1, i == 7, 0);
      if (i == 8) s1 = {count_hi, count_lo};
    end
    read_count(s2);
    check("R9 first snapshot", s1, 5);
    check("R9 no count lost", s1 + s2, 20);
    for (int i = 0; i < 300; i++) step(0, 1, 0, 0);
    idle(4);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    check("R9 upper byte", count_hi, 1);
    check("R9 lower byte", count_lo, 44);
  endtask

  task automatic t_sat();
    int v;
    do_reset(1'b1, 1'b0, 1'b0, 1'b0);
    cur_req = "R8";
    for (int i = 0; i < 65540; i++) step(0, 1, 0, 0);
    read_count(v);
    check("R8 saturated", v, 65535);
    read_count(v);
    check("R9 cleared after latch", v, 0);
  endtask

  initial begin
    t_reset();
    t_dual();
    t_binary();
    t_neg_inv();
    t_pos_inv();
    t_edge();
    t_latch();
    t_sat();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule